// File: doc/BRIEF.md
# Flip-Aware Raster Interrupt Timer

This block produces the periodic CPU interrupt, the vertical-blank flag and a two-state CPU-speed phase for a 256-line raster display. The screen can be mirrored vertically. When it is, the effective vertical count runs backwards. The interrupt edges then shift by half a stride, so the interrupt keeps the same spacing on the flipped picture.

The video timing generator pulses `line_stb` for one clock at each new raster line and presents the line number on `raster_line` in the same cycle. The flip control is sampled only on that strobe. A change of orientation therefore takes effect at a line boundary, and no interrupt edge is lost or doubled. The CPU clears a pending interrupt by pulsing `irq_ack`. Every output is a register that changes on the clock edge that samples the strobe. The one exception is `irq`, which `irq_ack` can also clear.

Top module: `raster_irq_timer`

## Requirements
- R1: After synchronous reset, `eff_v` is 0, `vblank` is 1, `irq` is 0 and `speed_phase` is 0.
- R2: With `flip` low at a strobe, `eff_v` becomes `raster_line` on the edge that samples the strobe.
- R3: With `flip` high at a strobe, `eff_v` becomes (256 − `raster_line`) mod 256 on the edge that samples the strobe.
- R4: `flip` and `raster_line` have no effect on any output on cycles without `line_stb`.
- R5: A strobe whose new effective count V has V[3:0] = 0 and V[4] equal to the sampled `flip` is an update point. At an update point `irq` takes the value of the inverse of V[5]. Unflipped, `irq` rises at 0, 64, 128 and 192 and falls at 32, 96, 160 and 224. Flipped, it rises at 16, 80, 144 and 208 and falls at 48, 112, 176 and 240.
- R6: `irq` keeps its value at every strobe that is not an update point, unless it is acknowledged.
- R7: `irq_ack` high at an edge clears `irq`. An update point in the same cycle takes priority over the acknowledge.
- R8: `vblank` is 1 exactly while `eff_v` is below 24.
- R9: `speed_phase` goes to 1 when the new effective count is 224 and to 0 when it is 0. At every other count it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_stb | input | 1 | One-cycle pulse at each new raster line |
| raster_line | input | 8 | Current raster line, valid with `line_stb` |
| flip | input | 1 | Vertical flip control, sampled with `line_stb` |
| irq_ack | input | 1 | Interrupt acknowledge, clears `irq` |
| eff_v | output | 8 | Effective vertical count |
| irq | output | 1 | Level-sensitive interrupt request |
| vblank | output | 1 | Vertical-blank flag |
| speed_phase | output | 1 | CPU-speed phase select |

## Verification
The hardest cases to reach from the ports are an orientation change between two strobes and an acknowledge that lands on the same edge as an update point. The orientation change must leave every output untouched until the next line. With the simultaneous acknowledge, the new interrupt level must survive. The stimulus first sweeps every raster line in both orientations against an arithmetic model. It then places a flip toggle in the idle cycles after a strobe. Finally it raises the acknowledge in the same cycle as the strobe of a rising-edge line, and again on a non-update line, to show that the acknowledge still works there.

// File: rtl/rti_pkg.sv
package rti_pkg;

    // Speed phase encoding: 0 while the active picture region runs, 1 after
    // the late split line until the count wraps to zero.
    typedef enum logic {
        PHASE_LOW  = 1'b0,
        PHASE_HIGH = 1'b1
    } speed_phase_e;

endpackage

// File: rtl/rti_vcount.sv
module rti_vcount #(
    parameter int V_W        = 8,
    parameter int VBLANK_END = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_stb,
    input  logic [V_W-1:0] raster_line,
    input  logic           flip,
    output logic [V_W-1:0] v_next,
    output logic [V_W-1:0] eff_v,
    output logic           vblank
);

    localparam logic [V_W-1:0] VB_LIMIT = V_W'(VBLANK_END);

    typedef struct packed {
        logic [V_W-1:0] v;
        logic           blank;
    } vstate_t;

    vstate_t st_d, st_q;

    // Mirrored count: the raster counter runs backwards under flip.
    always_comb begin
        v_next = flip ? ({V_W{1'b0}} - raster_line) : raster_line;
    end

    always_comb begin
        st_d = st_q;
        if (line_stb) begin
            st_d.v     = v_next;
            st_d.blank = (v_next < VB_LIMIT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.v     <= '0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_v  = st_q.v;
    assign vblank = st_q.blank;

endmodule

// File: rtl/rti_irq_gen.sv
module rti_irq_gen #(
    parameter int V_W         = 8,
    parameter int STRIDE_LOG2 = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_stb,
    input  logic [V_W-1:0] v_next,
    input  logic           flip,
    input  logic           irq_ack,
    output logic           irq
);

    localparam int HALF_BIT = STRIDE_LOG2 - 1;
    localparam int LOW_TOP  = STRIDE_LOG2 - 2;

    typedef struct packed {
        logic level;
    } istate_t;

    istate_t st_d, st_q;
    logic    at_point;

    // Update points sit every stride lines; under flip they move by half a
    // stride, which the half-stride bit matching the flip control encodes.
    always_comb begin
        at_point = line_stb
                && (v_next[LOW_TOP:0] == '0)
                && (v_next[HALF_BIT] == flip);
    end

    always_comb begin
        st_d = st_q;
        if (at_point) begin
            st_d.level = ~v_next[STRIDE_LOG2];
        end else if (irq_ack) begin
            st_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.level <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.level;

endmodule

// File: rtl/rti_speed_phase.sv
module rti_speed_phase
    import rti_pkg::*;
#(
    parameter int V_W       = 8,
    parameter int SPLIT_LO  = 0,
    parameter int SPLIT_HI  = 224
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_stb,
    input  logic [V_W-1:0] v_next,
    output logic           speed_phase
);

    localparam logic [V_W-1:0] LO_V = V_W'(SPLIT_LO);
    localparam logic [V_W-1:0] HI_V = V_W'(SPLIT_HI);

    typedef struct packed {
        speed_phase_e ph;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_stb) begin
            if (v_next == HI_V) begin
                st_d.ph = PHASE_HIGH;
            end else if (v_next == LO_V) begin
                st_d.ph = PHASE_LOW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph <= PHASE_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    assign speed_phase = (st_q.ph == PHASE_HIGH);

endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer #(
    parameter int V_W         = 8,
    parameter int STRIDE_LOG2 = 5,
    parameter int VBLANK_END  = 24,
    parameter int SPLIT_LO    = 0,
    parameter int SPLIT_HI    = 224
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_stb,
    input  logic [V_W-1:0] raster_line,
    input  logic           flip,
    input  logic           irq_ack,
    output logic [V_W-1:0] eff_v,
    output logic           irq,
    output logic           vblank,
    output logic           speed_phase
);

    logic [V_W-1:0] v_next;

    rti_vcount #(
        .V_W        (V_W),
        .VBLANK_END (VBLANK_END)
    ) u_vcount (
        .clk         (clk),
        .rst         (rst),
        .line_stb    (line_stb),
        .raster_line (raster_line),
        .flip        (flip),
        .v_next      (v_next),
        .eff_v       (eff_v),
        .vblank      (vblank)
    );

    rti_irq_gen #(
        .V_W         (V_W),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .line_stb (line_stb),
        .v_next   (v_next),
        .flip     (flip),
        .irq_ack  (irq_ack),
        .irq      (irq)
    );

    rti_speed_phase #(
        .V_W      (V_W),
        .SPLIT_LO (SPLIT_LO),
        .SPLIT_HI (SPLIT_HI)
    ) u_phase (
        .clk         (clk),
        .rst         (rst),
        .line_stb    (line_stb),
        .v_next      (v_next),
        .speed_phase (speed_phase)
    );

endmodule

// File: rtl/raster_irq_timer_chk.sv
module raster_irq_timer_chk #(
    parameter int V_W         = 8,
    parameter int STRIDE_LOG2 = 5,
    parameter int VBLANK_END  = 24,
    parameter int SPLIT_HI    = 224
) (
    input logic           clk,
    input logic           rst,
    input logic           line_stb,
    input logic [V_W-1:0] raster_line,
    input logic           flip,
    input logic           irq_ack,
    input logic [V_W-1:0] eff_v,
    input logic           irq,
    input logic           vblank,
    input logic           speed_phase
);

    logic [V_W-1:0] want_v;
    logic           rise_pt;

    always_comb begin
        want_v  = flip ? ({V_W{1'b0}} - raster_line) : raster_line;
        rise_pt = (want_v[STRIDE_LOG2-2:0] == '0)
               && (want_v[STRIDE_LOG2-1] == flip)
               && !want_v[STRIDE_LOG2];
    end

    // R2
    eff_v_track_chk: assert property (@(posedge clk) disable iff (rst)
        line_stb |=> (eff_v == $past(want_v)));

    // R4
    eff_v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_stb |=> ($stable(eff_v) && $stable(vblank) && $stable(speed_phase)));

    // R8
    vblank_range_chk: assert property (@(posedge clk) disable iff (rst)
        vblank == (eff_v < V_W'(VBLANK_END)));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !line_stb) |=> !irq);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_stb && !irq_ack) |=> $stable(irq));

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (line_stb && rise_pt) |=> irq);

    // R9
    phase_high_chk: assert property (@(posedge clk) disable iff (rst)
        (line_stb && want_v == V_W'(SPLIT_HI)) |=> speed_phase);

endmodule

bind raster_irq_timer raster_irq_timer_chk #(
    .V_W         (V_W),
    .STRIDE_LOG2 (STRIDE_LOG2),
    .VBLANK_END  (VBLANK_END),
    .SPLIT_HI    (SPLIT_HI)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_stb    (line_stb),
    .raster_line (raster_line),
    .flip        (flip),
    .irq_ack     (irq_ack),
    .eff_v       (eff_v),
    .irq         (irq),
    .vblank      (vblank),
    .speed_phase (speed_phase)
);

// File: tb/raster_irq_timer_tb.sv
`timescale 1ns/1ps
module raster_irq_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0;
    logic [7:0] raster_line = '0;
    logic       flip = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] eff_v;
    logic       irq;
    logic       vblank;
    logic       speed_phase;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] exp_v     = '0;
    logic       exp_irq   = 1'b0;
    logic       exp_phase = 1'b0;

    always #2 clk = ~clk;

    raster_irq_timer u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_stb    (line_stb),
        .raster_line (raster_line),
        .flip        (flip),
        .irq_ack     (irq_ack),
        .eff_v       (eff_v),
        .irq         (irq),
        .vblank      (vblank),
        .speed_phase (speed_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One strobed line; updates the arithmetic model, outputs sampled after.
    task automatic drive_line(input logic [7:0] l, input logic f, input logic a);
        logic [7:0] ev;
        @(negedge clk);
        line_stb = 1'b1; raster_line = l; flip = f; irq_ack = a;
        @(negedge clk);
        line_stb = 1'b0; irq_ack = 1'b0;
        ev = f ? 8'((256 - int'(l)) % 256) : l;
        if (ev[3:0] == 4'd0 && ev[4] == f) exp_irq = ~ev[5];
        else if (a) exp_irq = 1'b0;
        if (ev == 8'd224) exp_phase = 1'b1;
        else if (ev == 8'd0) exp_phase = 1'b0;
        exp_v = ev;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " eff_v"}, int'(eff_v), int'(exp_v));
        chk("R8 vblank", int'(vblank), int'(exp_v < 8'd24));
        chk("R5/R6 irq", int'(irq), int'(exp_irq));
        chk("R9 speed_phase", int'(speed_phase), int'(exp_phase));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 eff_v", int'(eff_v), 0);
        chk("R1 vblank", int'(vblank), 1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 speed_phase", int'(speed_phase), 0);
        rst = 1'b0;

        // R2 full unflipped sweep, two frames
        for (int fr = 0; fr < 2; fr++)
            for (int l = 0; l < 256; l++) begin
                drive_line(8'(l), 1'b0, 1'b0);
                check_all("R2");
            end

        // R3 full flipped sweep, two frames
        for (int fr = 0; fr < 2; fr++)
            for (int l = 0; l < 256; l++) begin
                drive_line(8'(l), 1'b1, 1'b0);
                check_all("R3");
            end

        // R4 flip and line toggled between strobes: no output moves
        drive_line(8'd10, 1'b0, 1'b0);
        @(negedge clk); flip = 1'b1; raster_line = 8'd200;
        repeat (3) @(negedge clk);
        check_all("R4");
        flip = 1'b0;

        // R7 acknowledge alone clears a pending request
        drive_line(8'd64, 1'b0, 1'b0);
        chk("R5 rise at 64", int'(irq), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; exp_irq = 1'b0;
        chk("R7 ack clears", int'(irq), 0);
        // R6 non-update lines keep the cleared level
        drive_line(8'd65, 1'b0, 1'b0);
        chk("R6 hold after ack", int'(irq), 0);

        // R7 update point wins over simultaneous acknowledge
        drive_line(8'd128, 1'b0, 1'b1);
        chk("R7 point beats ack", int'(irq), 1);
        // R7 ack with strobe on non-update line clears
        drive_line(8'd129, 1'b0, 1'b1);
        chk("R7 ack on plain line", int'(irq), 0);

        // R5 flipped rise at 16 (raster 240)
        drive_line(8'd240, 1'b1, 1'b0);
        chk("R5 flipped rise at 16", int'(irq), 1);
        check_all("R3");

        summary();
        $finish;
    end

endmodule